// File: doc/BRIEF.md
# Serial Command and Phrase Address Receiver

This block is the serial host interface of a speech playback controller. The host shifts an 8-bit word into the block one bit at a time on a data pin, with a separate serial clock pin. A rising edge on a strobe pin then commits the word. The top bit of each word tags it as a command (1) or a phrase address (0). The lower seven bits carry the payload. A committed word leaves the block as a one-cycle strobe to the playback engine, together with its tag, its payload and the channel it targets.

Each playback channel has a holding slot. The slot is either free or occupied. A word is committed only when the channel picked by the channel-select pin is free. The slot stays occupied until the engine acknowledges that channel. The ready output reports the state of the selected channel's slot.

One command family does not go to the engine. It sets two general-purpose port outputs instead. All host pins are asynchronous and pass through a two-stage synchronizer before any edge is detected.

Top module: `serial_cmd_rx`

## Requirements
- R1: After reset, nar_o is 1 for every channel, port_o is 0 and word_valid_o is 0.
- R2: Words are shifted MSB first. The block takes one sd_i bit on each rising edge of sck_i. Bit 7 of the word is the tag (1 = command, 0 = phrase address) and bits 6:0 are the payload. A pin change sampled at clock edge k acts at edge k+2, and its effect is visible at the outputs after that edge.
- R3: A rising edge of st_i commits the word when exactly 8 bits have been received and the selected channel is free. The commit produces a one-cycle word_valid_o pulse with word_is_cmd_o, word_payload_o and word_ch_o (the value of ch_i) valid in that cycle.
- R4: Every rising edge of st_i clears the bit count. A st_i edge that arrives with fewer than 8 bits received produces no strobe.
- R5: Once 8 bits have been received, further sck_i edges before st_i are ignored. The committed word holds the first 8 bits.
- R6: A committed engine-bound word marks its channel occupied (nar_o = 0 while ch_i selects that channel). ack_i[c] frees channel c. An ack_i to a channel that is already free has no effect.
- R7: A st_i edge while the selected channel is occupied is dropped: no strobe, and port_o does not change.
- R8: A command whose payload bits 6:2 equal 5'b11010 loads payload bits 1:0 into port_o (bit 1 → port_o[1]). It produces no strobe and does not change any channel's state. It must still arrive while the selected channel is free.
- R9: Channels are independent. Occupying one channel does not block words sent to the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sd_i | input | 1 | Serial data from host |
| sck_i | input | 1 | Serial shift clock from host |
| st_i | input | 1 | Commit strobe; acts on its rising edge |
| ch_i | input | 1 | Channel select for commit and status |
| ack_i | input | 2 | Per-channel release from the playback engine |
| word_valid_o | output | 1 | One-cycle strobe for a committed word |
| word_is_cmd_o | output | 1 | Tag of the committed word (1 = command) |
| word_payload_o | output | 7 | Payload of the committed word |
| word_ch_o | output | 1 | Channel of the committed word |
| nar_o | output | 1 | Selected channel's slot is free |
| port_o | output | 2 | Command-driven general-purpose outputs |

## Verification
A wrong bit count or shift register shows up at the next commit. The strobe is then missing when it should fire, or it carries a payload shifted by one or more bits. A missed edge or a spurious edge in the synchronizers moves every port response by one clock. The cycle-by-cycle model catches this in the very cycle it happens. A stuck slot flag shows on nar_o as soon as ch_i selects that channel. It also shows at the next st_i edge, as a dropped word or as a word accepted when it should have been dropped. A wrong port decode changes port_o, or raises a strobe, in the cycle right after the commit edge.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int unsigned WORD_W_DEF   = 8;
  localparam int unsigned PORT_W_DEF   = 2;
  localparam int unsigned NUM_CH_DEF   = 2;
  localparam int unsigned SYNC_DEF     = 2;
  localparam int unsigned PORT_PFX_DEF = 'b11010;

  typedef enum logic {TAG_ADDR = 1'b0, TAG_CMD = 1'b1} word_tag_e;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= '0;
    else         chain_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= '0;
      else         chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/srx_edge.sv
module srx_edge #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/srx_shift.sv
module srx_shift #(
  parameter int unsigned WORD_W = 8,
  localparam int unsigned CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic              bit_i,
  input  logic              clear_i,
  output logic [WORD_W-1:0] word_o,
  output logic              full_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (sample_i && cnt_q != FULL_CNT) begin
      cnt_q <= cnt_q + 1'b1;
      sh_q  <= {sh_q[WORD_W-2:0], bit_i};  // MSB first
    end
  end

  assign word_o = sh_q;
  assign full_o = (cnt_q == FULL_CNT);
endmodule

// File: rtl/srx_hold.sv
module srx_hold #(
  parameter int unsigned NUM_CH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] take_i,
  input  logic [NUM_CH-1:0] ack_i,
  output logic [NUM_CH-1:0] free_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic free_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        free_q <= 1'b1;
      else if (take_i[c]) free_q <= 1'b0;
      else if (ack_i[c])  free_q <= 1'b1;
    end
    assign free_o[c] = free_q;
  end
endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx
  import srx_pkg::*;
#(
  parameter int unsigned WORD_W   = WORD_W_DEF,
  parameter int unsigned PORT_W   = PORT_W_DEF,
  parameter int unsigned NUM_CH   = NUM_CH_DEF,
  parameter int unsigned SYNC     = SYNC_DEF,
  parameter int unsigned PORT_PFX = PORT_PFX_DEF,
  localparam int unsigned PL_W    = WORD_W - 1,
  localparam int unsigned PFX_W   = PL_W - PORT_W,
  localparam int unsigned CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sd_i,
  input  logic              sck_i,
  input  logic              st_i,
  input  logic [CH_W-1:0]   ch_i,
  input  logic [NUM_CH-1:0] ack_i,
  output logic              word_valid_o,
  output logic              word_is_cmd_o,
  output logic [PL_W-1:0]   word_payload_o,
  output logic [CH_W-1:0]   word_ch_o,
  output logic              nar_o,
  output logic [PORT_W-1:0] port_o
);
  logic [1:0]        edge_lvl, edge_rise;
  logic [CH_W:0]     lvl_s;
  logic              sd_s, sck_rise, st_rise;
  logic [CH_W-1:0]   ch_s;
  logic [WORD_W-1:0] word;
  logic              cnt_full, is_port, accept;
  logic [NUM_CH-1:0] take, free_w;

  srx_sync #(.W(2), .STAGES(SYNC)) u_sync_edge (
    .clk_i, .rst_ni, .d_i({st_i, sck_i}), .q_o(edge_lvl));

  srx_sync #(.W(CH_W + 1), .STAGES(SYNC)) u_sync_lvl (
    .clk_i, .rst_ni, .d_i({ch_i, sd_i}), .q_o(lvl_s));

  srx_edge #(.W(2)) u_edge (
    .clk_i, .rst_ni, .lvl_i(edge_lvl), .rise_o(edge_rise));

  assign sd_s     = lvl_s[0];
  assign ch_s     = lvl_s[CH_W:1];
  assign sck_rise = edge_rise[0];
  assign st_rise  = edge_rise[1];

  srx_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i, .rst_ni, .sample_i(sck_rise), .bit_i(sd_s), .clear_i(st_rise),
    .word_o(word), .full_o(cnt_full));

  assign is_port = (word[WORD_W-1] == TAG_CMD) &&
                   (word[PL_W-1 -: PFX_W] == PFX_W'(PORT_PFX));
  assign accept  = st_rise && cnt_full && free_w[ch_s];

  always_comb begin
    take = '0;
    if (accept && !is_port) take[ch_s] = 1'b1;
  end

  srx_hold #(.NUM_CH(NUM_CH)) u_hold (
    .clk_i, .rst_ni, .take_i(take), .ack_i, .free_o(free_w));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_valid_o   <= 1'b0;
      word_is_cmd_o  <= 1'b0;
      word_payload_o <= '0;
      word_ch_o      <= '0;
      port_o         <= '0;
    end else begin
      word_valid_o <= accept && !is_port;
      if (accept && !is_port) begin
        word_is_cmd_o  <= word[WORD_W-1];
        word_payload_o <= word[PL_W-1:0];
        word_ch_o      <= ch_s;
      end
      if (accept && is_port) port_o <= word[PORT_W-1:0];
    end
  end

  assign nar_o = free_w[ch_s];
endmodule

// File: rtl/serial_cmd_rx_chk.sv
module serial_cmd_rx_chk #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned CH_W   = 1,
  parameter int unsigned PORT_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              word_valid_o,
  input logic [CH_W-1:0]   word_ch_o,
  input logic [PORT_W-1:0] port_o,
  input logic [NUM_CH-1:0] ack_i,
  input logic [NUM_CH-1:0] free_w,
  input logic              st_rise,
  input logic              cnt_full
);
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |=> !word_valid_o);  // R3

  AST_STROBE_NEEDS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> $past(cnt_full && st_rise));  // R4

  AST_CH_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> !free_w[word_ch_o]);  // R6

  AST_FREE_ONLY_ON_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((free_w & ~$past(free_w) & ~$past(ack_i)) == '0));  // R6

  AST_PORT_ON_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(port_o) |-> $past(st_rise && cnt_full));  // R8

  AST_PORT_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(port_o) |-> !word_valid_o);  // R8
endmodule

bind serial_cmd_rx serial_cmd_rx_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W), .PORT_W(PORT_W)) u_chk (
  .clk_i, .rst_ni, .word_valid_o, .word_ch_o, .port_o, .ack_i,
  .free_w, .st_rise, .cnt_full);

// File: tb/serial_cmd_rx_tb_top.sv
module serial_cmd_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 100000;
  localparam int HOLD       = 3;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sd_i = 0, sck_i = 0, st_i = 0;
  logic [0:0] ch_i = 0;
  logic [1:0] ack_i = 0;
  logic       word_valid_o, word_is_cmd_o, nar_o;
  logic [6:0] word_payload_o;
  logic [0:0] word_ch_o;
  logic [1:0] port_o;

  serial_cmd_rx dut_i (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference: pins act two edges after sampling
  int   h1[4], h2[4], h3[4];  // {sd, sck, st, ch}
  int   m_cnt;
  int   m_word;
  bit   m_free[2];
  bit   m_valid, m_cmd;
  int   m_pl, m_ch, m_port;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      foreach (h1[i]) begin h1[i] = 0; h2[i] = 0; h3[i] = 0; end
      m_cnt = 0; m_word = 0; m_free[0] = 1; m_free[1] = 1;
      m_valid = 0; m_cmd = 0; m_pl = 0; m_ch = 0; m_port = 0;
    end else begin
      bit sck_r, st_r, acc;
      int c;
      bit old_free[2];
      sck_r = h2[1] && !h3[1];
      st_r  = h2[2] && !h3[2];
      c     = h2[3];
      old_free = m_free;
      m_valid = 0;
      acc = 0;
      if (st_r) begin
        if (m_cnt == 8 && old_free[c]) begin
          if ((m_word >> 7) == 1 && ((m_word >> 2) & 'h1f) == 'h1a)
            m_port = m_word & 3;
          else begin
            acc = 1; m_valid = 1; m_cmd = m_word[7]; m_pl = m_word & 'h7f; m_ch = c;
          end
        end
        m_cnt = 0;
      end else if (sck_r && m_cnt < 8) begin
        m_word = ((m_word << 1) | h2[0]) & 'hff;
        m_cnt++;
      end
      for (int k = 0; k < 2; k++)
        m_free[k] = (acc && c == k) ? 1'b0 : (ack_i[k] ? 1'b1 : old_free[k]);
      h3 = h2; h2 = h1;
      h1[0] = sd_i; h1[1] = sck_i; h1[2] = st_i; h1[3] = ch_i;
    end
  end

  // per-cycle comparison and strobe capture
  int n_strobe = 0, last_word = -1, last_ch = -1;
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk(word_valid_o == m_valid, "R3 valid", word_valid_o, m_valid);
      if (m_valid) begin
        chk(word_is_cmd_o == m_cmd, "R3 tag", word_is_cmd_o, m_cmd);
        chk(word_payload_o == m_pl, "R2 payload", word_payload_o, m_pl);
        chk(word_ch_o == m_ch, "R3 channel", word_ch_o, m_ch);
      end
      chk(nar_o == m_free[h2[3]], "R6 nar", nar_o, m_free[h2[3]]);
      chk(port_o == m_port, "R8 port", port_o, m_port);
      if (word_valid_o) begin
        n_strobe++;
        last_word = {word_is_cmd_o, word_payload_o};
        last_ch = word_ch_o;
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic send_bits(input int w, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      sd_i = (i < 8) ? w[7-i] : 1'b1;
      sck_i = 0; wait_cyc(HOLD);
      sck_i = 1; wait_cyc(HOLD);
    end
    sck_i = 0; wait_cyc(HOLD);
  endtask

  task automatic commit(input int ch);
    ch_i = ch[0]; wait_cyc(HOLD);
    st_i = 1; wait_cyc(HOLD + 1);
    st_i = 0; wait_cyc(HOLD + 1);
  endtask

  task automatic ack(input int ch);
    ack_i[ch] = 1; wait_cyc(1); ack_i = 0; wait_cyc(2);
  endtask

  initial begin
    int n0;
    wait_cyc(3);
    rst_ni = 1;
    wait_cyc(2);
    // R1
    chk(nar_o == 1, "R1 nar ch0", nar_o, 1);
    chk(port_o == 0, "R1 port", port_o, 0);
    chk(word_valid_o == 0, "R1 valid", word_valid_o, 0);
    ch_i = 1; wait_cyc(4);
    chk(nar_o == 1, "R1 nar ch1", nar_o, 1);

    // R2/R3: address word to ch0
    send_bits('h25, 8); commit(0);
    chk(n_strobe == 1, "R3 strobe count", n_strobe, 1);
    chk(last_word == 'h25, "R2 word", last_word, 'h25);
    chk(last_ch == 0, "R3 ch", last_ch, 0);
    chk(nar_o == 0, "R6 ch0 busy", nar_o, 0);

    // R9: ch1 still free and accepts
    ch_i = 1; wait_cyc(4);
    chk(nar_o == 1, "R9 ch1 free", nar_o, 1);
    send_bits('h13, 8); commit(1);
    chk(last_word == 'h13 && last_ch == 1, "R9 ch1 word", last_word, 'h13);

    // R7: ch0 busy drops word
    n0 = n_strobe;
    send_bits('h85, 8); commit(0);
    chk(n_strobe == n0, "R7 dropped", n_strobe, n0);
    ack(0); wait_cyc(2);
    chk(nar_o == 1, "R6 ack frees", nar_o, 1);
    ack(0);
    chk(nar_o == 1, "R6 ack when free", nar_o, 1);

    // R4: short word discarded, counter cleared
    n0 = n_strobe;
    send_bits('hff, 5); commit(0);
    chk(n_strobe == n0, "R4 short dropped", n_strobe, n0);
    send_bits('hc7, 8); commit(0);
    chk(n_strobe == n0 + 1 && last_word == 'hc7, "R4 recount", last_word, 'hc7);
    ack(0);

    // R5: extra bits ignored
    send_bits('h5a, 10); commit(0);
    chk(last_word == 'h5a, "R5 overlong", last_word, 'h5a);
    ack(0);

    // R8: port commands
    n0 = n_strobe;
    send_bits('hea, 8); commit(0);
    chk(port_o == 2, "R8 port=2", port_o, 2);
    chk(n_strobe == n0, "R8 no strobe", n_strobe, n0);
    chk(nar_o == 1, "R8 nar kept", nar_o, 1);
    send_bits('he9, 8); commit(0);
    chk(port_o == 1, "R8 port=1", port_o, 1);

    // R3: other command goes to engine
    send_bits('h81, 8); commit(0);
    chk(last_word == 'h81, "R3 cmd tag", last_word, 'h81);

    // R7: port command while busy is dropped
    send_bits('hEB, 8); commit(0);
    chk(port_o == 1, "R7 port unchanged", port_o, 1);
    ack(0); ack(1);
    wait_cyc(5);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == WD_LIMIT && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule